// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a down-counting supervision timer for a processor subsystem. A slow-clock enable, divided by a fixed prescaler of 128, decrements a 12-bit counter. Software keeps the system alive by issuing a restart write. That write must carry a fixed key and must arrive while the counter has already fallen into a service window. The window is the region at or below a programmed delta value. A restart issued too soon is a fault, and so is a counter that runs out.

Each fault sets its own sticky status bit. Depending on the configuration, a fault also drives a fixed-length reset pulse, a level interrupt, or both. A one-time mode write sets the reload value, the window delta, the response enables and two freeze options. The freeze options stop counting while the processor is halted for debug or sleeping in idle.

Top module: `keyed_window_wdog`

## Requirements
- R1: After reset, `count` is 0xFFF, `wdt_rst` and `wdt_irq` are low and `status` is 0. The default configuration is reload 0xFFF, window 0xFFF, reset response on, interrupt off and no freezing.
- R2: While the block is not frozen and no reset pulse is active, `count` drops by one for every 128 cycles in which `slow_tick` is high. A restart or mode write clears the prescaler.
- R3: A restart is a write with `wr_en`=1, `wr_sel`=0, `wr_key`=0xA5 and `wr_data[0]`=1. When `count` is at or below the window delta, a restart reloads `count` with the programmed reload value. A restart with any other key has no effect.
- R4: A keyed restart while `count` is above the window delta is an early error. It sets `status[1]` and does not reload the counter.
- R5: A decrement while `count` is 0 is an underflow error and sets `status[0]`.
- R6: When the reset response is enabled, an error drives `wdt_rst` high for exactly 16 cycles. During the pulse `count` holds, and restart and mode writes are ignored. `count` reloads on the cycle `wdt_rst` falls.
- R7: `wdt_irq` is high whenever the interrupt response is enabled and either status bit is set.
- R8: With the reset response disabled, an underflow reloads `count` at once, and an early restart leaves `count` unchanged.
- R9: A mode write is `wr_en`=1, `wr_sel`=1, `wr_key`=0xA5. Its data fields are [11:0] reload, [23:12] window delta, [24] reset enable, [25] interrupt enable, [26] freeze in debug and [27] freeze in idle. It also loads `count` with the new reload value. Only the first mode write after reset takes effect.
- R10: With the matching freeze option set, `count` and the prescaler hold while `dbg_halt` or `cpu_idle` is high.
- R11: A `rd_clr` pulse clears both status bits. An error in the same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow-clock enable, one cycle per slow period |
| dbg_halt | input | 1 | Processor is in debug state |
| cpu_idle | input | 1 | Processor is in idle mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects restart, 1 selects mode |
| wr_key | input | 8 | Key carried by the write |
| wr_data | input | 28 | Write data (restart bit or mode fields) |
| rd_clr | input | 1 | Status read strobe, clears the sticky bits |
| status | output | 2 | Sticky errors: [1] early restart, [0] underflow |
| count | output | 12 | Current counter value |
| wdt_rst | output | 1 | Reset request pulse |
| wdt_irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that every input is synchronous to `clk` and that a write is a single-cycle strobe. The freeze-hold property only applies in cycles without a write, because a mode write may legally reload the counter while frozen. The bench keeps to these terms: it changes every input on the falling edge, drops `wr_en` after one cycle, and never writes during a frozen stretch it checks. A behavioural reference model advances on every rising edge from the same inputs. Its counter, prescaler, pulse and status values are compared with the ports on each falling edge.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

   // per-cycle command from the decode stage to the counter core
   typedef enum logic [2:0] {
      ACT_IDLE   = 3'd0,
      ACT_COUNT  = 3'd1,
      ACT_RELOAD = 3'd2,
      ACT_ARM    = 3'd3,
      ACT_HOLD   = 3'd4
   } wdw_act_e;

   // response and freeze options, packed in mode-write bit order
   typedef struct packed {
      logic frz_idle;
      logic frz_dbg;
      logic irq_en;
      logic rst_en;
   } wdw_flags_t;

   localparam wdw_flags_t FLAGS_AT_RESET = '{frz_idle: 1'b0, frz_dbg: 1'b0,
                                             irq_en: 1'b0, rst_en: 1'b1};

endpackage

// File: rtl/wdw_prescale.sv
module wdw_prescale #(
   parameter int unsigned PRE_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic at_max
);

   generate
      if (PRE_W == 0) begin : g_direct
         assign at_max = 1'b1;
      end else begin : g_div
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr) begin
               pre_q <= '0;
            end else if (adv) begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign at_max = &pre_q;
      end
   endgenerate

endmodule

// File: rtl/wdw_count_core.sv
module wdw_count_core import wdw_pkg::*; #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned RST_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wdw_act_e         act,
   input  logic             step,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             busy
);

   localparam int unsigned RSTC_W = $clog2(RST_CYC + 1);
   localparam logic [RSTC_W-1:0] RSTC_START = RSTC_W'(RST_CYC);
   localparam logic [RSTC_W-1:0] RSTC_LAST  = RSTC_W'(1);

   logic [CNT_W-1:0]  cnt_q;
   logic [RSTC_W-1:0] rstc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '1;
         rstc_q <= '0;
      end else begin
         unique case (act)
            ACT_RELOAD: cnt_q <= load_val;
            ACT_ARM:    rstc_q <= RSTC_START;
            ACT_HOLD: begin
               rstc_q <= rstc_q - 1'b1;
               if (rstc_q == RSTC_LAST) cnt_q <= load_val;
            end
            ACT_COUNT: begin
               if (step) cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign cnt  = cnt_q;
   assign busy = (rstc_q != '0);

endmodule

// File: rtl/wdw_err_status.sv
module wdw_err_status #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unf_err,
   input  logic       early_err,
   input  logic       rd_clr,
   input  logic       irq_en,
   output logic [1:0] status,
   output logic       irq
);

   logic unf_q, early_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unf_q   <= 1'b0;
         early_q <= 1'b0;
      end else begin
         unf_q   <= (unf_q & ~rd_clr) | unf_err;
         early_q <= (early_q & ~rd_clr) | early_err;
      end
   end

   assign status = {early_q, unf_q};

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_en & (unf_q | early_q);
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_en & (unf_q | early_q);
      end
   endgenerate

endmodule

// File: rtl/keyed_window_wdog.sv
module keyed_window_wdog import wdw_pkg::*; #(
   parameter int unsigned        CNT_W   = 12,
   parameter int unsigned        PRE_W   = 7,
   parameter int unsigned        KEY_W   = 8,
   parameter logic [KEY_W-1:0]   KEY     = 8'hA5,
   parameter int unsigned        RST_CYC = 16,
   parameter bit                 IRQ_REG = 1'b0,
   localparam int unsigned       DATA_W  = 2*CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              dbg_halt,
   input  logic              cpu_idle,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clr,
   output logic [1:0]        status,
   output logic [CNT_W-1:0]  count,
   output logic              wdt_rst,
   output logic              wdt_irq
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("keyed_window_wdog: CNT_W must be at least 4");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("keyed_window_wdog: RST_CYC must be at least 1");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("keyed_window_wdog: KEY_W must be at least 1");
      end
   endgenerate

   // configuration
   logic [CNT_W-1:0] reload_q, delta_q;
   wdw_flags_t       flags_q;
   logic             locked_q;

   logic [CNT_W-1:0] new_reload, new_delta;
   wdw_flags_t       new_flags;

   assign new_reload = wr_data[CNT_W-1:0];
   assign new_delta  = wr_data[2*CNT_W-1:CNT_W];
   assign new_flags  = wdw_flags_t'(wr_data[DATA_W-1:2*CNT_W]);

   // decode
   logic     rst_busy, key_ok, mode_wr, restart_req, frozen, tick_en;
   logic     pre_max, step, early_err, unf_err, pre_clr;
   wdw_act_e act;
   logic [CNT_W-1:0] load_val;

   assign key_ok      = (wr_key == KEY);
   assign mode_wr     = wr_en & wr_sel & key_ok & ~locked_q & ~rst_busy;
   assign restart_req = wr_en & ~wr_sel & key_ok & wr_data[0] & ~rst_busy;
   assign frozen      = (flags_q.frz_dbg & dbg_halt) | (flags_q.frz_idle & cpu_idle);
   assign tick_en     = slow_tick & ~frozen;
   assign step        = tick_en & pre_max;
   assign early_err   = restart_req & (count > delta_q);
   assign unf_err     = ~rst_busy & ~mode_wr & ~restart_req & step & (count == '0);
   assign load_val    = mode_wr ? new_reload : reload_q;

   always_comb begin
      if (rst_busy)                                act = ACT_HOLD;
      else if (mode_wr)                            act = ACT_RELOAD;
      else if (restart_req && !early_err)          act = ACT_RELOAD;
      else if ((early_err || unf_err) && flags_q.rst_en) act = ACT_ARM;
      else if (unf_err)                            act = ACT_RELOAD;
      else if (early_err)                          act = ACT_IDLE;
      else if (tick_en)                            act = ACT_COUNT;
      else                                         act = ACT_IDLE;
   end

   assign pre_clr = (act == ACT_RELOAD) || (act == ACT_ARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         delta_q  <= '1;
         flags_q  <= FLAGS_AT_RESET;
         locked_q <= 1'b0;
      end else if (mode_wr) begin
         reload_q <= new_reload;
         delta_q  <= new_delta;
         flags_q  <= new_flags;
         locked_q <= 1'b1;
      end
   end

   wdw_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pre_clr),
      .adv    (act == ACT_COUNT),
      .at_max (pre_max)
   );

   wdw_count_core #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .step     (step),
      .load_val (load_val),
      .cnt      (count),
      .busy     (rst_busy)
   );

   wdw_err_status #(.IRQ_REG(IRQ_REG)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .unf_err   (unf_err),
      .early_err (early_err),
      .rd_clr    (rd_clr),
      .irq_en    (flags_q.irq_en),
      .status    (status),
      .irq       (wdt_irq)
   );

   assign wdt_rst = rst_busy;

endmodule

// File: rtl/wdw_checker.sv
module wdw_checker #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned RST_CYC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload_val,
   input logic [1:0]       status,
   input logic             wdt_rst,
   input logic             wdt_irq,
   input logic             irq_en,
   input logic             frz_dbg,
   input logic             dbg_halt,
   input logic             wr_en
);

   localparam int unsigned LEN_W = $clog2(RST_CYC + 2);
   localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(RST_CYC);

   logic [LEN_W-1:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (wdt_rst) hi_len <= hi_len + 1'b1;
      else              hi_len <= '0;
   end

   // R6: pulse never outlasts its length
   p_rst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> (hi_len < LEN_FULL));

   // R6: a finished pulse lasted exactly the full length
   p_rst_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_rst && hi_len != '0) |-> (hi_len == LEN_FULL));

   // R6: counter holds while the pulse is active
   p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_rst && $past(wdt_rst)) |-> $stable(count));

   // R2: counter moves only by one step down or to the reload value
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ((count == $past(count) - 1'b1) || (count == reload_val)));

   // R7: interrupt only with an enabled response and a pending error
   p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_irq |-> (irq_en && status != 2'b00));

   // R10: debug freeze holds the counter when no write intervenes
   p_dbg_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_dbg && dbg_halt && !wr_en && !wdt_rst) |=> $stable(count));

endmodule

bind keyed_window_wdog wdw_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_wdw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .count      (count),
   .reload_val (reload_q),
   .status     (status),
   .wdt_rst    (wdt_rst),
   .wdt_irq    (wdt_irq),
   .irq_en     (flags_q.irq_en),
   .frz_dbg    (flags_q.frz_dbg),
   .dbg_halt   (dbg_halt),
   .wr_en      (wr_en)
);

// File: tb/test_keyed_window_wdog.sv
module test_keyed_window_wdog;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam logic [7:0] GOOD_KEY = 8'hA5;
   localparam logic [7:0] BAD_KEY  = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0, dbg_halt = 1'b0, cpu_idle = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_clr = 1'b0;
   logic [7:0]  wr_key = '0;
   logic [27:0] wr_data = '0;
   logic [1:0]  status;
   logic [11:0] count;
   logic        wdt_rst, wdt_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_window_wdog i_keyed_window_wdog (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
      .cpu_idle(cpu_idle), .wr_en(wr_en), .wr_sel(wr_sel), .wr_key(wr_key),
      .wr_data(wr_data), .rd_clr(rd_clr), .status(status), .count(count),
      .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_cnt, m_pre, m_rstc, m_reload, m_delta;
   bit m_unf, m_early, m_rsten, m_irqen, m_fd, m_fi, m_lock;

   always @(posedge clk) begin
      bit busy, keyok, mw, rr, frz, tick, wrap, early, unf;
      if (!rst_n) begin
         m_cnt = 4095; m_pre = 0; m_rstc = 0; m_reload = 4095; m_delta = 4095;
         m_unf = 0; m_early = 0; m_rsten = 1; m_irqen = 0; m_fd = 0; m_fi = 0; m_lock = 0;
      end else begin
         busy  = (m_rstc != 0);
         keyok = (wr_key == GOOD_KEY);
         mw    = wr_en && wr_sel && keyok && !m_lock && !busy;
         rr    = wr_en && !wr_sel && keyok && wr_data[0] && !busy;
         frz   = (m_fd && dbg_halt) || (m_fi && cpu_idle);
         tick  = slow_tick && !frz;
         wrap  = tick && (m_pre == 127);
         early = rr && (m_cnt > m_delta);
         unf   = !busy && !mw && !rr && wrap && (m_cnt == 0);
         m_unf   = (m_unf && !rd_clr) || unf;
         m_early = (m_early && !rd_clr) || early;
         if (busy) begin
            m_rstc--;
            if (m_rstc == 0) m_cnt = m_reload;
         end else if (mw) begin
            m_reload = wr_data[11:0]; m_delta = wr_data[23:12];
            m_rsten = wr_data[24]; m_irqen = wr_data[25];
            m_fd = wr_data[26]; m_fi = wr_data[27]; m_lock = 1;
            m_cnt = m_reload; m_pre = 0;
         end else if (rr && !early) begin
            m_cnt = m_reload; m_pre = 0;
         end else if ((early || unf) && m_rsten) begin
            m_rstc = 16; m_pre = 0;
         end else if (unf) begin
            m_cnt = m_reload; m_pre = 0;
         end else if (early) begin
         end else if (tick) begin
            if (wrap) m_cnt--;
            m_pre = (m_pre + 1) % 128;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 count vs model", count, m_cnt);
         chk("R6 wdt_rst vs model", wdt_rst, m_rstc != 0);
         chk("R7 wdt_irq vs model", wdt_irq, m_irqen && (m_unf || m_early));
         chk("R11 status vs model", status, {m_early, m_unf});
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [27:0] mode_word(int rl, int dl, bit re, bit ie, bit fd, bit fi);
      return {fi, fd, ie, re, 12'(dl), 12'(rl)};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; slow_tick = 0; dbg_halt = 0; cpu_idle = 0;
      wr_en = 0; rd_clr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_write(bit sel, logic [7:0] key, logic [27:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_key = key; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_key = '0;
   endtask

   task automatic do_rdclr();
      rd_clr = 1'b1;
      @(negedge clk);
      rd_clr = 1'b0;
   endtask

   task automatic wait_count(int v);
      for (int i = 0; i < 20000; i++) begin
         if (count == v) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_status(int bitpos);
      for (int i = 0; i < 20000; i++) begin
         if (status[bitpos]) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_rst_fall();
      for (int i = 0; i < 100; i++) begin
         if (!wdt_rst) break;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      int held;
      do_reset();
      // R1 reset state
      chk("R1 count at reset", count, 12'hFFF);
      chk("R1 wdt_rst at reset", wdt_rst, 0);
      chk("R1 wdt_irq at reset", wdt_irq, 0);
      chk("R1 status at reset", status, 0);

      // R3 wrong key restart ignored
      do_write(1'b0, BAD_KEY, 28'h1);
      chk("R3 bad key restart ignored", count, 12'hFFF);

      // R9 first mode write takes effect, second ignored
      do_write(1'b1, GOOD_KEY, mode_word(6, 3, 1, 1, 1, 0));
      chk("R9 mode write loads counter", count, 6);
      do_write(1'b1, GOOD_KEY, mode_word(9, 9, 0, 0, 0, 0));
      chk("R9 second mode write ignored", count, 6);

      // R4/R6/R7 early restart with reset response
      slow_tick = 1'b1;
      do_write(1'b0, GOOD_KEY, 28'h1);
      chk("R4 early error flagged", status, 2'b10);
      chk("R6 reset pulse starts", wdt_rst, 1);
      chk("R7 irq on early error", wdt_irq, 1);
      held = 1;
      do_write(1'b0, GOOD_KEY, 28'h1); // ignored during pulse
      held++;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (wdt_rst) held++;
      end
      chk("R6 pulse still high at 16th cycle", wdt_rst, 1);
      @(negedge clk);
      chk("R6 pulse length 16", held + 0, 16);
      chk("R6 pulse ended", wdt_rst, 0);
      chk("R6 count reloaded after pulse", count, 6);
      do_rdclr();
      chk("R11 status cleared by read", status, 0);

      // R3 legal restart inside window
      wait_count(3);
      do_write(1'b0, GOOD_KEY, 28'h1);
      chk("R3 legal restart reloads", count, 6);
      chk("R3 legal restart no error", status, 0);

      // R10 debug freeze
      dbg_halt = 1'b1;
      repeat (300) @(negedge clk);
      chk("R10 debug freeze holds count", count, 6);
      dbg_halt = 1'b0;
      cpu_idle = 1'b1;   // idle freeze not enabled in this configuration
      repeat (300) @(negedge clk);
      cpu_idle = 1'b0;

      // bad key inside window has no effect
      wait_count(3);
      do_write(1'b0, BAD_KEY, 28'h1);
      chk("R3 bad key inside window ignored", status, 0);

      // R5 underflow with reset response
      wait_status(0);
      chk("R5 underflow flagged", status, 2'b01);
      chk("R5 count at zero during pulse", count, 0);
      chk("R6 pulse on underflow", wdt_rst, 1);
      wait_rst_fall();
      do_rdclr();

      // Phase B: no reset response, idle freeze
      do_reset();
      do_write(1'b1, GOOD_KEY, mode_word(2, 1, 0, 1, 0, 1));
      slow_tick = 1'b1;
      do_write(1'b0, GOOD_KEY, 28'h1);
      chk("R8 early without reset: status", status, 2'b10);
      chk("R8 early without reset: no pulse", wdt_rst, 0);
      chk("R8 early without reset: count kept", count, 2);
      chk("R7 irq level", wdt_irq, 1);
      do_rdclr();
      chk("R7 irq drops after clear", wdt_irq, 0);
      wait_status(0);
      chk("R8 underflow reloads at once", count, 2);
      chk("R8 underflow no pulse", wdt_rst, 0);
      cpu_idle = 1'b1;
      held = count;
      repeat (300) @(negedge clk);
      chk("R10 idle freeze holds count", count, held);
      cpu_idle = 1'b0;
      do_rdclr();

      // Phase C: defaults, sparse ticks
      do_reset();
      for (int i = 0; i < 1200; i++) begin
         slow_tick = (i % 2 == 0);
         @(negedge clk);
      end
      slow_tick = 1'b0;
      chk("R2 count after 600 ticks", count, 12'hFFF - 4);
      do_write(1'b0, GOOD_KEY, 28'h1);
      chk("R1 default window allows restart", count, 12'hFFF);
      repeat (20) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule